// File: doc/BRIEF.md
# Masked Local Interrupt Encoder

This block merges sixteen level-sensitive interrupt lines into a single request. Each line's level is captured into a status register on every clock edge. A sixteen-bit enable mask selects which captured lines may raise the combined request. The pending set is the status bits ANDed with the mask.

Software reaches the block through a small sixteen-bit register port with two locations. A read-only source location reports the lowest-numbered pending line as a vector equal to (index + 1) shifted left by two. That value can be used directly as a jump-table offset, and zero means nothing is pending. A read/write location holds the enable mask. Every other offset reads as zero and ignores writes.

Top module: `local_irq_encoder`

## Requirements
- R1: Each status bit equals the level of its input line as sampled at the previous rising clock edge; status follows the level with no edge detection or latching.
- R2: The combined request `irqOut` is high exactly when at least one bit of (status AND mask) is set.
- R3: A read of offset 0x0 returns ((n + 1) << 2), where n is the lowest-numbered pending line (line 0 gives 4, line 15 gives 64), or 0 when no line is pending.
- R4: Offset 0x2 reads back the mask. A write there updates the mask at the next clock edge, and `irqOut` and the source value reflect the new mask from then on.
- R5: After reset the mask is 0x0010, all status bits are clear and `irqOut` is low.
- R6: Reads of any offset other than 0x0 and 0x2 (including the odd offsets 0x1 and 0x3) return 0, and writes to them leave the mask unchanged.
- R7: Writes to offset 0x0 are ignored: the mask keeps its value.
- R8: Reading the source location changes neither the mask nor the status.
- R9: A line whose mask bit is clear never appears in the source value, even when it is active and has a lower index than a pending line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 16 | Level-sensitive interrupt lines |
| regAddr | input | 4 | Byte offset of the register access |
| regRd | input | 1 | Read strobe; read data is valid in the same cycle |
| regWr | input | 1 | Write strobe; takes effect at the clock edge |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data; zero when no valid read is selected |
| irqOut | output | 1 | Combined masked interrupt request |

## Verification
The priority encoder is exercised with an idle input set, single lines at both ends of the range, several lines active together where only the lowest should win, and active low-index lines masked out beneath a higher pending line. These cases separate a lowest-first encoder from a highest-first one, and an encoder fed by the masked set from one fed by raw status. Further patterns lower a line after it was high, to tell level following from sticky latching. Directed cases cover the reset mask, ignored writes to the source location and to unused even and odd offsets, and repeated source reads that must leave the state unchanged.

// File: rtl/lie_pkg.sv
package lie_pkg;
  localparam int SRC_OFFSET  = 0;
  localparam int MASK_OFFSET = 2;

  typedef struct packed {
    logic wrMask;
    logic rdSrc;
    logic rdMask;
  } regStrobe_t;
endpackage

// File: rtl/lie_ctrl.sv
module lie_ctrl
  import lie_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  output regStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] SRC_ADDR  = ADDR_W'(SRC_OFFSET);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_OFFSET);

  logic hitSrc;
  logic hitMask;

  assign hitSrc  = (regAddr == SRC_ADDR);
  assign hitMask = (regAddr == MASK_ADDR);

  // The source location is read-only, so only the mask has a write strobe.
  always_comb begin
    strobe        = '0;
    strobe.wrMask = regWr & hitMask;
    strobe.rdSrc  = regRd & hitSrc;
    strobe.rdMask = regRd & hitMask;
  end

  always_comb begin
    assert ($countones({strobe.rdSrc, strobe.rdMask}) <= 1) else $error("AST_ONE_READ_SOURCE"); // R6
  end
endmodule

// File: rtl/lie_datapath.sv
module lie_datapath
  import lie_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 16,
  parameter logic [NUM_LINES-1:0] MASK_RESET = 16'h0010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  regStrobe_t           strobe,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irqOut
);
  logic [NUM_LINES-1:0] statusQ;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] pendingSet;
  logic [DATA_W-1:0]    srcVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= irqIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= MASK_RESET;
    end else if (strobe.wrMask) begin
      maskQ <= regWdata[NUM_LINES-1:0];
    end
  end

  assign pendingSet = statusQ & maskQ;
  assign irqOut     = |pendingSet;

  // Scan from the top down so the lowest pending index is the last one assigned.
  always_comb begin
    srcVec = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pendingSet[i]) srcVec = DATA_W'((i + 1) << 2);
    end
  end

  always_comb begin
    regRdata = '0;
    if (strobe.rdSrc)  regRdata = srcVec;
    if (strobe.rdMask) regRdata = DATA_W'(maskQ);
  end

  AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusQ == $past(irqIn)); // R1
  AST_SRC_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (srcVec == '0) == !irqOut); // R2
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrMask |=> maskQ == $past(regWdata[NUM_LINES-1:0])); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrMask |=> $stable(maskQ)); // R7
endmodule

// File: rtl/local_irq_encoder.sv
module local_irq_encoder
  import lie_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regRd,
  input  logic                 regWr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irqOut
);
  regStrobe_t strobe;

  lie_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .regAddr(regAddr),
    .regRd  (regRd),
    .regWr  (regWr),
    .strobe (strobe)
  );

  lie_datapath #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .MASK_RESET(NUM_LINES'(16'h0010))
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .strobe  (strobe),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/test_local_irq_encoder.sv
module test_local_irq_encoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic [3:0]  regAddr = '0;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  local_irq_encoder i_local_irq_encoder (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regAddr(regAddr),
    .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  localparam int NV = 10;
  localparam logic [15:0] V_IN   [NV] = '{16'h0000, 16'h0001, 16'h8000, 16'h8001, 16'h00F0,
                                          16'h0003, 16'h0103, 16'hFFFF, 16'h0010, 16'h0020};
  localparam logic [15:0] V_MASK [NV] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF,
                                          16'hFFFC, 16'hFFFE, 16'h8000, 16'h0010, 16'h0010};
  localparam logic [15:0] V_SRC  [NV] = '{16'd0, 16'd4, 16'd64, 16'd4, 16'd20,
                                          16'd0, 16'd8, 16'd64, 16'd20, 16'd0};
  localparam logic        V_IRQ  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                                          1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    regRd = 1'b0;
  endtask

  task automatic setLines(input logic [15:0] v);
    @(negedge clk);
    irqIn = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    irqIn = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    irqIn = '0;
    rstN = 1'b1;
    // R5: reset state
    check("R5 irq after reset", {15'b0, irqOut}, 16'h0);
    readReg(4'h2, rd); check("R5 mask reset", rd, 16'h0010);
    readReg(4'h0, rd); check("R5 source reset", rd, 16'h0000);
    setLines(16'h0011);
    readReg(4'h0, rd); check("R5 default mask enables line 4", rd, 16'd20);
    check("R5 irq with default mask", {15'b0, irqOut}, 16'h1);

    for (int k = 0; k < NV; k++) begin
      writeReg(4'h2, V_MASK[k]);
      setLines(V_IN[k]);
      readReg(4'h0, rd);
      check("R3/R9 source vector", rd, V_SRC[k]);
      check("R2 irq level", {15'b0, irqOut}, {15'b0, V_IRQ[k]});
    end

    // R1: level following, no latching
    writeReg(4'h2, 16'hFFFF);
    setLines(16'h0004);
    check("R1 line high", {15'b0, irqOut}, 16'h1);
    setLines(16'h0000);
    check("R1 line dropped", {15'b0, irqOut}, 16'h0);
    readReg(4'h0, rd); check("R1 source after drop", rd, 16'h0000);

    // R4: mask readback and immediate effect
    writeReg(4'h2, 16'h1234);
    readReg(4'h2, rd); check("R4 mask readback", rd, 16'h1234);
    setLines(16'h0020);
    check("R4 irq with enabling mask", {15'b0, irqOut}, 16'h1);
    writeReg(4'h2, 16'h0000);
    check("R4 irq drops on mask clear", {15'b0, irqOut}, 16'h0);
    readReg(4'h0, rd); check("R4 source after mask clear", rd, 16'h0000);

    // R7: writes to source ignored
    writeReg(4'h2, 16'h00A5);
    writeReg(4'h0, 16'hFFFF);
    readReg(4'h2, rd); check("R7 mask after source write", rd, 16'h00A5);

    // R6: other offsets
    writeReg(4'h1, 16'hFFFF);
    writeReg(4'h3, 16'h0000);
    writeReg(4'h6, 16'h5A5A);
    readReg(4'h2, rd); check("R6 mask after stray writes", rd, 16'h00A5);
    readReg(4'h1, rd); check("R6 odd offset reads 0", rd, 16'h0000);
    readReg(4'h4, rd); check("R6 offset 4 reads 0", rd, 16'h0000);
    readReg(4'hE, rd); check("R6 offset E reads 0", rd, 16'h0000);

    // R8: source reads have no side effect
    setLines(16'h0084);
    readReg(4'h0, rd); check("R8 first source read", rd, 16'd12);
    readReg(4'h0, rd); check("R8 second source read", rd, 16'd12);
    readReg(4'h2, rd); check("R8 mask unchanged", rd, 16'h00A5);
    check("R8 irq unchanged", {15'b0, irqOut}, 16'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule